// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block is the last digital stage of one channel of an 8-bit sampling converter. Each sample arrives with a valid strobe and is registered onto an 8-bit output bus. On the way, the sample may be replaced by one of seven built-in test patterns: three fixed codes, a checkerboard, two pseudorandom sequences and an all-ones/all-zeros toggle. The word is then recoded into the selected number format and can be bit-inverted.

The live sample is taken to be offset binary. The fixed codes and the checkerboard are defined in offset binary and go through the recoder. The pseudorandom and toggle patterns skip the recoder, because their bit patterns are meaningful only as raw bits. Two reseed strobes restart the two pseudorandom generators. An output-enable control releases the bus to high impedance without disturbing the stored word.

Top module: `sfmt_top`

## Requirements
- R1: After reset the stored output word is 0x00, `dout_valid_o` is 0, the checkerboard/toggle phase is 0 and both generators hold all ones.
- R2: With test mode 000, a sample presented with `smp_valid_i` high appears, after recoding and inversion, on `dout_o` one clock later with `dout_valid_o` high. A clock with `smp_valid_i` low clears `dout_valid_o` and leaves the word unchanged.
- R3: Format select 00 passes the offset-binary word unchanged. 01 gives two's complement, which is the word with its MSB flipped. 10 gives Gray code, computed as b ^ (b >> 1). The reserved value 11 behaves as 00.
- R4: When `invert_i` is high, the final word is the bitwise complement of the word it would otherwise be. This applies in every test mode.
- R5: Test mode 001 gives 0x80, 010 gives 0xFF and 011 gives 0x00. Each of these is then recoded and inverted as in R3 and R4.
- R6: A phase bit starts at 0 and flips on every valid sample, whatever the mode. Mode 100 gives 0xAA at phase 0 and 0x55 at phase 1, and this word is recoded. Mode 111 gives 0xFF at phase 0 and 0x00 at phase 1, and this word is not recoded.
- R7: The short generator is a 9-bit register s that shifts left, taking feedback s[8]^s[4] (x^9+x^5+1) into bit 0. It makes 8 shifts on every valid sample, whatever the mode. Mode 110 emits the low 8 bits of its updated state (bit 0 is the newest bit), with no recoding.
- R8: The long generator works the same way with 23 bits and feedback s[22]^s[17] (x^23+x^18+1). Mode 101 emits its low 8 bits.
- R9: `pn_long_rst_i` and `pn_short_rst_i` each reload only their own generator with all ones in that clock, in place of any advance. A word emitted from that generator in that clock is 0xFF before inversion.
- R10: In any nonzero test mode, `smp_data_i` has no effect on the output.
- R11: When `out_en_i` is low, `dout_o` is high impedance. The stored word and `dout_valid_o` keep updating, and the stored word shows again as soon as `out_en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 8 | Live sample, offset binary |
| test_sel_i | input | 3 | Test mode select (000 = live) |
| pn_long_rst_i | input | 1 | Reseed strobe for the 23-bit generator |
| pn_short_rst_i | input | 1 | Reseed strobe for the 9-bit generator |
| fmt_sel_i | input | 2 | Number format select |
| invert_i | input | 1 | Complement the final word |
| out_en_i | input | 1 | Bus drive enable, active high |
| dout_o | output | 8 | Formatted output word, tri-stated when disabled |
| dout_valid_o | output | 1 | Word on `dout_o` was updated at the last clock |

## Verification
The assertions assume that the inputs are held stable from one falling edge to the next. The bench drives every input on the falling edge only. The assertions also assume that the generators never reach the all-zero lock-up state. This holds only because the generators are seeded with all ones, so the bench applies reseeds only through the strobes. The phase and generator properties take for granted that a valid strobe can come on any cycle. The bench therefore mixes idle cycles into every pattern run, which also covers the hold behaviour.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
    typedef enum logic [2:0] {
        TM_LIVE    = 3'b000,
        TM_MID     = 3'b001,
        TM_POSFS   = 3'b010,
        TM_NEGFS   = 3'b011,
        TM_CHECK   = 3'b100,
        TM_PNLONG  = 3'b101,
        TM_PNSHORT = 3'b110,
        TM_TOGGLE  = 3'b111
    } test_mode_e;

    typedef enum logic [1:0] {
        FMT_OBIN = 2'b00,
        FMT_TWOS = 2'b01,
        FMT_GRAY = 2'b10,
        FMT_RSVD = 2'b11
    } fmt_e;
endpackage

// File: rtl/sfmt_prbs.sv
module sfmt_prbs #(
    parameter int LEN = 9,
    parameter int TAP = 5,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic         restart_i,
    output logic [W-1:0] word_o
);
    localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

    typedef struct packed {
        logic [LEN-1:0] sr;
    } prbs_st_t;

    prbs_st_t st_q, st_d;

    always_comb begin
        logic [LEN-1:0] s;
        s = st_q.sr;
        for (int k = 0; k < W; k++) begin
            s = {s[LEN-2:0], s[LEN-1] ^ s[TAP-1]};
        end
        st_d = st_q;
        if (restart_i) begin
            st_d.sr = SEED;
        end else if (adv_i) begin
            st_d.sr = s;
        end
    end

    assign word_o = st_d.sr[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a restart strobe reloads the seed
    a_r9_reseed: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.sr == SEED));

    // R7 / R8: seeded generator never locks up at zero
    always_comb begin
        if (rst_n) begin
            a_r7_nonzero: assert (st_q.sr != '0);
        end
    end
endmodule

// File: rtl/sfmt_pattern_src.sv
module sfmt_pattern_src
    import sfmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [2:0]   mode_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] pn_long_i,
    input  logic [W-1:0] pn_short_i,
    output logic [W-1:0] word_o,
    output logic         raw_o
);
    localparam logic [W-1:0] MID_CODE = W'(1) << (W - 1);
    localparam logic [W-1:0] ALT_A    = {(W / 2){2'b10}};

    typedef struct packed {
        logic phase;
    } pat_st_t;

    pat_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_comb begin
        word_o = live_i;
        raw_o  = 1'b0;
        unique case (test_mode_e'(mode_i))
            TM_LIVE:    word_o = live_i;
            TM_MID:     word_o = MID_CODE;
            TM_POSFS:   word_o = '1;
            TM_NEGFS:   word_o = '0;
            TM_CHECK:   word_o = st_q.phase ? ~ALT_A : ALT_A;
            TM_PNLONG:  begin word_o = pn_long_i;  raw_o = 1'b1; end
            TM_PNSHORT: begin word_o = pn_short_i; raw_o = 1'b1; end
            TM_TOGGLE:  begin word_o = st_q.phase ? '0 : '1; raw_o = 1'b1; end
            default:    word_o = live_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: phase flips on every valid sample and holds otherwise
    a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (st_q.phase != $past(st_q.phase)));
    a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(st_q.phase));
endmodule

// File: rtl/sfmt_recode.sv
module sfmt_recode
    import sfmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] word_i,
    input  logic [1:0]   fmt_i,
    input  logic         raw_i,
    input  logic         invert_i,
    output logic [W-1:0] word_o
);
    localparam logic [W-1:0] MSB_MASK = W'(1) << (W - 1);

    logic [W-1:0] coded;

    always_comb begin
        coded = word_i;
        if (!raw_i) begin
            unique case (fmt_e'(fmt_i))
                FMT_TWOS: coded = word_i ^ MSB_MASK;
                FMT_GRAY: coded = word_i ^ (word_i >> 1);
                default:  coded = word_i;
            endcase
        end
        word_o = invert_i ? ~coded : coded;
    end

    // R3: two's complement leaves the low bits alone (up to inversion)
    always_comb begin
        if (!raw_i && fmt_i == FMT_TWOS) begin
            a_r3_twos_low: assert (word_o[W-2:0] == (word_i[W-2:0] ^ {(W-1){invert_i}}));
        end
    end
endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
    import sfmt_pkg::*;
#(
    parameter int W         = 8,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid_i,
    input  logic [W-1:0] smp_data_i,
    input  logic [2:0]   test_sel_i,
    input  logic         pn_long_rst_i,
    input  logic         pn_short_rst_i,
    input  logic [1:0]   fmt_sel_i,
    input  logic         invert_i,
    input  logic         out_en_i,
    output logic [W-1:0] dout_o,
    output logic         dout_valid_o
);
    localparam int NGEN = 2;
    localparam int LENS [NGEN] = '{LONG_LEN, SHORT_LEN};
    localparam int TAPS [NGEN] = '{LONG_TAP, SHORT_TAP};

    logic [W-1:0] gen_word [NGEN];
    logic [NGEN-1:0] gen_rst;
    logic [W-1:0] pat_word, fmt_word;
    logic         pat_raw;

    assign gen_rst = {pn_short_rst_i, pn_long_rst_i};

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        sfmt_prbs #(.LEN(LENS[g]), .TAP(TAPS[g]), .W(W)) u_prbs (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv_i     (smp_valid_i),
            .restart_i (gen_rst[g]),
            .word_o    (gen_word[g])
        );
    end

    sfmt_pattern_src #(.W(W)) u_pat (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (smp_valid_i),
        .mode_i     (test_sel_i),
        .live_i     (smp_data_i),
        .pn_long_i  (gen_word[0]),
        .pn_short_i (gen_word[1]),
        .word_o     (pat_word),
        .raw_o      (pat_raw)
    );

    sfmt_recode #(.W(W)) u_rec (
        .word_i   (pat_word),
        .fmt_i    (fmt_sel_i),
        .raw_i    (pat_raw),
        .invert_i (invert_i),
        .word_o   (fmt_word)
    );

    typedef struct packed {
        logic [W-1:0] word;
        logic         vld;
    } out_st_t;

    out_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_valid_i;
        if (smp_valid_i) begin
            st_d.word = fmt_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= '0;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o       = out_en_i ? st_q.word : {W{1'bz}};
    assign dout_valid_o = st_q.vld;

    // R2: an idle clock leaves the stored word alone
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> ($stable(st_q.word) && !dout_valid_o));
    // R5: a fixed test code in offset binary without inversion reaches the register
    a_r5_posfs: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && test_sel_i == TM_POSFS && fmt_sel_i == FMT_OBIN && !invert_i)
        |=> (st_q.word == '1));
endmodule

// File: tb/sfmt_top_test.sv
module sfmt_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic [2:0] mode = 3'b000;
    logic       rl = 1'b0, rs = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic       inv = 1'b0;
    logic       oe = 1'b1;
    tri1  [7:0] bus;
    logic       dvld;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    sfmt_top uut (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(vld), .smp_data_i(din),
        .test_sel_i(mode), .pn_long_rst_i(rl), .pn_short_rst_i(rs),
        .fmt_sel_i(fmt), .invert_i(inv), .out_en_i(oe),
        .dout_o(bus), .dout_valid_o(dvld)
    );

    // reference model state
    logic [8:0]  m9  = '1;
    logic [22:0] m23 = '1;
    bit          ph  = 1'b0;
    logic [7:0]  m_word = 8'h00;
    bit          m_vld  = 1'b0;

    function automatic logic [7:0] recode(input logic [7:0] b, input logic [1:0] f);
        if (f == 2'b01) return {~b[7], b[6:0]};
        if (f == 2'b10) return b ^ {1'b0, b[7:1]};
        return b;
    endfunction

    task automatic model_step();
        logic [7:0] w;
        bit raw;
        if (rs) m9 = '1;
        else if (vld) for (int k = 0; k < 8; k++) m9 = {m9[7:0], m9[8] ^ m9[4]};
        if (rl) m23 = '1;
        else if (vld) for (int k = 0; k < 8; k++) m23 = {m23[21:0], m23[22] ^ m23[17]};
        raw = 0;
        case (mode)
            3'd0: w = din;
            3'd1: w = 8'h80;
            3'd2: w = 8'hFF;
            3'd3: w = 8'h00;
            3'd4: w = ph ? 8'h55 : 8'hAA;
            3'd5: begin w = m23[7:0]; raw = 1; end
            3'd6: begin w = m9[7:0];  raw = 1; end
            default: begin w = ph ? 8'h00 : 8'hFF; raw = 1; end
        endcase
        if (!raw) w = recode(w, fmt);
        if (inv) w = ~w;
        if (vld) begin
            m_word = w;
            ph = ~ph;
        end
        m_vld = vld;
    endtask

    task automatic check(input string tag);
        logic [7:0] exp_bus;
        exp_bus = oe ? m_word : 8'hFF;  // pull-up reads ones when released
        n_chk++;
        if (bus !== exp_bus || dvld !== m_vld) begin
            n_bad++;
            $display("FAIL %s: bus=%h vld=%b expected bus=%h vld=%b", tag, bus, dvld, exp_bus, m_vld);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic set(input bit v, input logic [7:0] d, input logic [2:0] m,
                       input logic [1:0] f, input bit i);
        vld = v; din = d; mode = m; fmt = f; inv = i;
    endtask

    initial begin : watchdog
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");

        // R2 / R3 / R4: live data in every format, with and without inversion
        d = 8'h3C;
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 2; i++) begin
                for (int k = 0; k < 4; k++) begin
                    d = d * 8'd37 + 8'd11;
                    set(1, d, 3'd0, 2'(f), i[0]);
                    tick(f == 0 ? "R2 live" : (i == 1 ? "R4 invert" : "R3 format"));
                end
            end
        end
        // R2: idle clocks hold the word
        set(0, 8'hA5, 3'd0, 2'b00, 0);
        tick("R2 hold");
        tick("R2 hold");

        // R5 / R10: fixed codes with changing live input
        for (int m = 1; m <= 3; m++) begin
            for (int f = 0; f < 3; f++) begin
                set(1, 8'(m * 40 + f * 7), 3'(m), 2'(f), f[0]);
                tick("R5 fixed code");
                din = ~din;
                tick("R10 live ignored");
            end
        end

        // R6: checkerboard and toggle with gaps
        for (int k = 0; k < 12; k++) begin
            set(k % 3 != 2, 8'(k), 3'd4, 2'(k % 3), k[2]);
            tick("R6 checkerboard");
        end
        for (int k = 0; k < 10; k++) begin
            set(k % 4 != 3, 8'(k), 3'd7, 2'b01, k[0]);
            tick("R6 toggle");
        end

        // R9: reseed short generator then run PN9
        set(1, 8'h00, 3'd6, 2'b10, 0);
        rs = 1;
        tick("R9 short reseed");
        rs = 0;
        for (int k = 0; k < 40; k++) begin
            set(k % 5 != 4, 8'(k * 13), 3'd6, 2'(k % 4), k[3]);
            tick("R7 pn9");
        end
        // R9: reseed long generator, short one keeps running
        set(1, 8'h00, 3'd5, 2'b01, 0);
        rl = 1;
        tick("R9 long reseed");
        rl = 0;
        for (int k = 0; k < 60; k++) begin
            set(k % 7 != 6, 8'(k * 29), 3'd5, 2'(k % 4), k[1]);
            tick("R8 pn23");
        end
        set(1, 8'h00, 3'd6, 2'b00, 0);
        tick("R9 short unaffected by long reseed");
        rs = 1;
        set(0, 8'h00, 3'd6, 2'b00, 0);
        tick("R9 reseed without sample");
        rs = 0;
        set(1, 8'h00, 3'd6, 2'b00, 0);
        tick("R9 after idle reseed");

        // R11: release bus, keep updating, then re-enable
        set(1, 8'h00, 3'd3, 2'b00, 0);
        oe = 0;
        tick("R11 bus released");
        set(1, 8'h5A, 3'd0, 2'b00, 0);
        tick("R11 bus released");
        oe = 1;
        set(0, 8'h00, 3'd0, 2'b00, 0);
        #1;
        check("R11 word restored");
        tick("R11 hold after enable");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule